// File: doc/BRIEF.md
# Time-Slot Scheduled Crossbar Switch

This block is a crossbar that connects its data inputs to its data outputs with no arbitration. A slot counter runs freely and steps through a routing schedule that is worked out offline. For every slot, the schedule gives each output either one source input or an "unused" mark. The schedule already keeps any two inputs from reaching the same output in the same slot. Contention therefore cannot arise, and every connection gets a fixed share of cycles and a fixed latency.

The schedule is loaded from a parameter at reset. While the switch is stopped (`run_en` low), software can change individual entries through a small write port. Each output has one register stage. The word that an output shows in the cycle after slot t is the word its scheduled input carried during slot t. Several outputs may name the same input in one slot, which gives a broadcast.

Top module: `tss_crossbar`

## Requirements
- R1: After reset, `slot_idx` is 0, every `out_valid` bit is 0, every `out_data` lane is 0, and the schedule equals `INIT_TABLE`.
- R2: While `run_en` is high, `slot_idx` goes up by one on each clock. After `NUM_SLOTS-1` it returns to 0.
- R3: A clock with `run_en` low sets `slot_idx` to 0. The next enabled run therefore always begins at slot 0.
- R4: Take an enabled clock where `slot_idx` equals t. Output o then registers the data and valid bit of the input that the schedule names for (t, o). Field layout:
  - Schedule entry (t, o) sits at bits `[(t*NUM_PORTS+o)*SEL_W +: SEL_W]`, with `SEL_W = clog2(NUM_PORTS+1)`.
  - Input and output lane p sit at bits `[p*DATA_W +: DATA_W]` of the data buses.
  - Lane p is at bit p of the valid buses.
- R5: A schedule entry of `NUM_PORTS` or more (code 3 at the default size) marks the output as unused for that slot. The output then registers valid 0 and data 0.
- R6: Two or more outputs may take the same input in the same slot, and each of them receives that input's word.
- R7: A clock with `cfg_we` high and `run_en` low writes `cfg_sel` into schedule entry (`cfg_slot`, `cfg_out`). The new routing applies from the next enabled pass onward.
- R8: A write request while `run_en` is high is ignored, and the schedule keeps its previous contents.
- R9: A clock with `run_en` low registers valid 0 and data 0 on every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables the slot counter and the data path; a low value opens the schedule for writes |
| in_data | input | NUM_PORTS*DATA_W | Input data lanes, lane p at bits p*DATA_W |
| in_valid | input | NUM_PORTS | Input valid flags, bit p for lane p |
| cfg_we | input | 1 | Request to write one schedule entry |
| cfg_slot | input | SLOT_W | Slot index of the entry to write |
| cfg_out | input | PORT_W | Output index of the entry to write |
| cfg_sel | input | SEL_W | Source input code to store (NUM_PORTS or more means unused) |
| out_data | output | NUM_PORTS*DATA_W | Registered output data lanes |
| out_valid | output | NUM_PORTS | Registered output valid flags |
| slot_idx | output | SLOT_W | Current time slot |

## Verification
The bound checker watches these on every cycle:
- the counter steps by one and wraps to 0;
- the counter returns to 0 and the outputs go quiet whenever the switch is stopped;
- the schedule stays frozen while the switch runs;
- an output marked unused never raises valid.

Some behaviour shows only in the bench's scenarios, which compare each output lane with an independent model of the schedule. These are:
- the actual data routing for each slot;
- broadcasts;
- that a write made while stopped changes the routing on the next pass;
- that a write attempted while running leaves the routing as it was.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;

    // width of a select code: one code per input plus the "unused" code
    function automatic int sel_width(input int ports);
        return $clog2(ports + 1);
    endfunction

    // width of an index over n items, at least one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tss_slot_counter.sv
`timescale 1ns/1ps
module tss_slot_counter #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = tss_pkg::idx_width(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    output logic [SLOT_W-1:0] slot_q
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_en) begin
            cnt_d.slot = '0;
        end else if (cnt_q.slot == LAST) begin
            cnt_d.slot = '0;
        end else begin
            cnt_d.slot = cnt_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign slot_q = cnt_q.slot;

endmodule

// File: rtl/tss_slot_table.sv
`timescale 1ns/1ps
module tss_slot_table #(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_PORTS = 3,
    localparam int SEL_W  = tss_pkg::sel_width(NUM_PORTS),
    localparam int SLOT_W = tss_pkg::idx_width(NUM_SLOTS),
    localparam int PORT_W = tss_pkg::idx_width(NUM_PORTS),
    localparam int ROW_W  = NUM_PORTS * SEL_W,
    localparam int TBL_W  = NUM_SLOTS * ROW_W,
    parameter logic [TBL_W-1:0] INIT_TABLE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [PORT_W-1:0] cfg_out,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [ROW_W-1:0]  rd_row,
    output logic [TBL_W-1:0]  table_flat
);

    typedef struct packed {
        logic [TBL_W-1:0] cells;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic wr_ok;

    always_comb begin
        tbl_d = tbl_q;
        wr_ok = cfg_we && !run_en
                && (int'(cfg_slot) < NUM_SLOTS)
                && (int'(cfg_out) < NUM_PORTS);
        if (wr_ok) begin
            tbl_d.cells[(int'(cfg_slot) * NUM_PORTS + int'(cfg_out)) * SEL_W +: SEL_W] = cfg_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q.cells <= INIT_TABLE;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    always_comb begin
        rd_row = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (int'(rd_slot) == s) begin
                rd_row = tbl_q.cells[s*ROW_W +: ROW_W];
            end
        end
    end

    assign table_flat = tbl_q.cells;

endmodule

// File: rtl/tss_out_lane.sv
`timescale 1ns/1ps
module tss_out_lane #(
    parameter int NUM_PORTS = 3,
    parameter int DATA_W    = 16,
    localparam int SEL_W    = tss_pkg::sel_width(NUM_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_en,
    input  logic [SEL_W-1:0]              sel,
    input  logic [NUM_PORTS*DATA_W-1:0]   in_data,
    input  logic [NUM_PORTS-1:0]          in_valid,
    output logic [DATA_W-1:0]             out_data,
    output logic                          out_valid
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = '0;
        if (run_en) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (int'(sel) == p) begin
                    lane_d.dat = in_data[p*DATA_W +: DATA_W];
                    lane_d.vld = in_valid[p];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign out_data  = lane_q.dat;
    assign out_valid = lane_q.vld;

endmodule

// File: rtl/tss_crossbar.sv
`timescale 1ns/1ps
module tss_crossbar #(
    parameter int NUM_PORTS = 3,
    parameter int DATA_W    = 16,
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = tss_pkg::sel_width(NUM_PORTS),
    localparam int SLOT_W   = tss_pkg::idx_width(NUM_SLOTS),
    localparam int PORT_W   = tss_pkg::idx_width(NUM_PORTS),
    localparam int ROW_W    = NUM_PORTS * SEL_W,
    localparam int TBL_W    = NUM_SLOTS * ROW_W,
    parameter logic [TBL_W-1:0] INIT_TABLE = 24'h572264
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_en,
    input  logic [NUM_PORTS*DATA_W-1:0] in_data,
    input  logic [NUM_PORTS-1:0]        in_valid,
    input  logic                        cfg_we,
    input  logic [SLOT_W-1:0]           cfg_slot,
    input  logic [PORT_W-1:0]           cfg_out,
    input  logic [SEL_W-1:0]            cfg_sel,
    output logic [NUM_PORTS*DATA_W-1:0] out_data,
    output logic [NUM_PORTS-1:0]        out_valid,
    output logic [SLOT_W-1:0]           slot_idx
);

    logic [ROW_W-1:0] cur_row;
    logic [TBL_W-1:0] table_flat;

    tss_slot_counter #(
        .NUM_SLOTS (NUM_SLOTS)
    ) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .slot_q (slot_idx)
    );

    tss_slot_table #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_PORTS  (NUM_PORTS),
        .INIT_TABLE (INIT_TABLE)
    ) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cfg_we     (cfg_we),
        .cfg_slot   (cfg_slot),
        .cfg_out    (cfg_out),
        .cfg_sel    (cfg_sel),
        .rd_slot    (slot_idx),
        .rd_row     (cur_row),
        .table_flat (table_flat)
    );

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_lane
        tss_out_lane #(
            .NUM_PORTS (NUM_PORTS),
            .DATA_W    (DATA_W)
        ) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_en    (run_en),
            .sel       (cur_row[o*SEL_W +: SEL_W]),
            .in_data   (in_data),
            .in_valid  (in_valid),
            .out_data  (out_data[o*DATA_W +: DATA_W]),
            .out_valid (out_valid[o])
        );
    end

endmodule

// File: rtl/tss_crossbar_chk.sv
`timescale 1ns/1ps
module tss_crossbar_chk #(
    parameter int NUM_PORTS = 3,
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W  = tss_pkg::sel_width(NUM_PORTS),
    localparam int SLOT_W = tss_pkg::idx_width(NUM_SLOTS),
    localparam int TBL_W  = NUM_SLOTS * NUM_PORTS * SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [NUM_PORTS-1:0] out_valid,
    input logic [TBL_W-1:0]  table_flat
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && slot_idx == LAST) |=> (slot_idx == '0));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && slot_idx != LAST) |=> (slot_idx == SLOT_W'($past(slot_idx) + 1'b1)));

    // R3
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (slot_idx == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (out_valid == '0));

    // R8
    table_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(table_flat));

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_unused
        // R5
        unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_en && (int'(table_flat[(int'(slot_idx) * NUM_PORTS + o) * SEL_W +: SEL_W]) >= NUM_PORTS))
            |=> !out_valid[o]);
    end

endmodule

bind tss_crossbar tss_crossbar_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_SLOTS (NUM_SLOTS)
) i_tss_crossbar_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .slot_idx   (slot_idx),
    .out_valid  (out_valid),
    .table_flat (table_flat)
);

// File: tb/test_tss_crossbar.sv
`timescale 1ns/1ps
module test_tss_crossbar;

    localparam int NP = 3;
    localparam int DW = 16;
    localparam int NS = 4;
    // schedule: slot0 {0,1,2}, slot1 {1,2,0}, slot2 {2,0,unused}, slot3 {1,1,1}
    localparam logic [23:0] SCHED = {6'b01_01_01, 6'b11_00_10, 6'b00_10_01, 6'b10_01_00};

    // vector layout: {valid[2:0], d2, d1, d0}
    localparam logic [50:0] VEC [0:7] = '{
        {3'b111, 16'hA002, 16'hA001, 16'hA000},
        {3'b111, 16'hB002, 16'hB001, 16'hB000},
        {3'b111, 16'hC002, 16'hC001, 16'hC000},
        {3'b111, 16'hD002, 16'hD001, 16'hD000},
        {3'b101, 16'h1234, 16'h5678, 16'h9ABC},
        {3'b010, 16'hFFFF, 16'h0F0F, 16'hF0F0},
        {3'b100, 16'h0001, 16'h0002, 16'h0003},
        {3'b011, 16'h7777, 16'h8888, 16'h9999}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [NP*DW-1:0] in_data = '0;
    logic [NP-1:0] in_valid = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_slot = '0;
    logic [1:0] cfg_out = '0;
    logic [1:0] cfg_sel = '0;
    logic [NP*DW-1:0] out_data;
    logic [NP-1:0] out_valid;
    logic [1:0] slot_idx;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int ms = 0;
    logic [1:0] tbl [NS][NP];

    always #2 clk = ~clk;

    tss_crossbar #(
        .NUM_PORTS (NP), .DATA_W (DW), .NUM_SLOTS (NS), .INIT_TABLE (SCHED)
    ) i_tss_crossbar (
        .clk (clk), .rst_n (rst_n), .run_en (run_en),
        .in_data (in_data), .in_valid (in_valid),
        .cfg_we (cfg_we), .cfg_slot (cfg_slot), .cfg_out (cfg_out), .cfg_sel (cfg_sel),
        .out_data (out_data), .out_valid (out_valid), .slot_idx (slot_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare at the following negedge
    task automatic step(input logic [50:0] v, input logic en, input string tag);
        logic [DW-1:0] ed [NP];
        logic [NP-1:0] ev;
        int es;
        string lbl;
        for (int o = 0; o < NP; o++) begin
            int s = int'(tbl[ms][o]);
            if (!en || s >= NP) begin
                ed[o] = '0; ev[o] = 1'b0;
            end else begin
                ed[o] = v[s*DW +: DW]; ev[o] = v[48 + s];
            end
        end
        es = en ? ((ms == NS - 1) ? 0 : ms + 1) : 0;
        in_data = v[47:0];
        in_valid = v[50:48];
        run_en = en;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        for (int o = 0; o < NP; o++) begin
            lbl = tag;
            if (en && int'(tbl[ms][o]) >= NP) lbl = "R5";       // unused output
            else if (en && tag == "R4" && ms == 3) lbl = "R6";  // broadcast slot
            check({lbl, " data"}, 32'(out_data[o*DW +: DW]), 32'(ed[o]));
            check({lbl, " valid"}, 32'(out_valid[o]), 32'(ev[o]));
        end
        check(en ? "R2 slot" : "R3 slot", 32'(slot_idx), 32'(es));
        ms = es;
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int o = 0; o < NP; o++)
                tbl[s][o] = SCHED[(s*NP + o)*2 +: 2];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 slot", 32'(slot_idx), 32'd0);
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 data", out_data[31:0], 32'd0);

        // R4 R5 R6: two passes over the initial schedule
        for (int i = 0; i < 8; i++) step(VEC[i], 1'b1, "R4");

        // R3 R9: stopping resets the slot and quiets outputs
        step(VEC[0], 1'b1, "R4");
        step(VEC[1], 1'b0, "R9");
        step(VEC[2], 1'b0, "R9");

        // R7: rewrite entries while stopped
        cfg_we = 1'b1; cfg_slot = 2'd1; cfg_out = 2'd0; cfg_sel = 2'd2;
        step(VEC[3], 1'b0, "R9");
        tbl[1][0] = 2'd2;
        cfg_we = 1'b1; cfg_slot = 2'd2; cfg_out = 2'd2; cfg_sel = 2'd0;
        step(VEC[4], 1'b0, "R9");
        tbl[2][2] = 2'd0;

        // R8: attempted write while running is dropped (model unchanged)
        cfg_we = 1'b1; cfg_slot = 2'd0; cfg_out = 2'd0; cfg_sel = 2'd3;
        step(VEC[5], 1'b1, "R8");
        for (int i = 0; i < 8; i++) step(VEC[i], 1'b1, "R7");

        // R3: restart after a stop begins at slot 0
        step(VEC[6], 1'b0, "R3");
        step(VEC[7], 1'b1, "R3");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule